// File: doc/BRIEF.md
# Burst Beat Address Sequencer

This block walks through the beats of a memory burst, one beat per advance pulse. A load strobe captures the burst description: the start byte address, a length field, a size field and a burst kind. The length field holds the beat count minus one. The size field is the base-2 logarithm of the bytes per beat. After the load, the block presents the byte address of the current beat. It also presents a mask of the data-bus byte lanes that the beat occupies and a flag that marks the final beat. When the final beat is consumed, a done pulse follows.

Three burst kinds are supported. The first repeats a single address, as a queue register needs. The second walks upward through memory, and an unaligned start gives a partial first beat. The third walks upward inside an aligned window and folds back to the window's base, which suits a critical-word-first line fill. Requests that cannot be sequenced are refused with an error flag.

The block performs no channel handshaking, moves no data and does not check page crossings. A bus master or slave engine pairs it with its own handshake logic and pulses the advance input once per accepted beat.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset, busy, last_beat, done, bad_req and lane_mask are all zero and beat_addr is zero.
- R2: A legal load makes busy high on the next cycle and presents start_addr as the first beat address. A new load takes effect even while a burst is in progress.
- R3: With burst_kind = 1 (incrementing), each beat after the first is the previous address aligned down to 2^beat_size bytes, plus 2^beat_size.
- R4: With burst_kind = 0 (fixed), every beat presents start_addr unchanged.
- R5: With burst_kind = 2 (wrapping), the window is (burst_len+1)·2^beat_size bytes, aligned to its own size. Each beat adds 2^beat_size to the address, and reaching the top of the window returns the address to the window base.
- R6: Lane i of lane_mask stands for byte i of the bus, where i = address mod BUS_BYTES. While busy, the lanes from the beat address offset up to the end of its 2^beat_size-aligned block are set. This makes an unaligned first beat partial (for example, 0x1003 with 8-byte beats gives 0xF8). While idle, the mask is zero.
- R7: last_beat is high while busy exactly on beat index burst_len. An advance on that beat drops busy on the next cycle, and done is high for that one cycle only.
- R8: A load is refused when any of these holds: burst_kind = 3; beat_size exceeds log2(BUS_BYTES); or the kind is wrapping and either burst_len is not 1, 3, 7 or 15 or start_addr is not aligned to 2^beat_size. A refused load sets bad_req and leaves busy low. A legal load clears bad_req.
- R9: An advance while idle has no effect: beat_addr, busy and lane_mask keep their values and done stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Captures a new burst description |
| start_addr | input | ADDR_W | Byte address of the first beat |
| burst_len | input | 8 | Beat count minus one |
| beat_size | input | 3 | log2 of bytes per beat |
| burst_kind | input | 2 | 0 fixed, 1 incrementing, 2 wrapping |
| advance | input | 1 | Consumes the current beat |
| beat_addr | output | ADDR_W | Byte address of the current beat |
| lane_mask | output | BUS_BYTES | Byte lanes occupied by the current beat |
| busy | output | 1 | A burst is in progress |
| last_beat | output | 1 | Current beat is the final one |
| done | output | 1 | One-cycle pulse after the final beat is consumed |
| bad_req | output | 1 | The last load was refused |

## Verification
The fold-back of a wrapping burst is the hardest behaviour to reach. It only occurs when a legal length, an aligned start and an offset inside the window all line up, and the fold then happens on a beat chosen by that offset. The bench loads wrapping bursts that start in the middle of the window with two different beat sizes, so the fold lands on different beats. It compares every beat with addresses it computes itself. The refusal paths are reached by loading each illegal combination in turn, and a legal load follows each one to show that the error flag clears.

// File: rtl/burst_addr_pkg.sv
`timescale 1ns/1ps
package burst_addr_pkg;

    typedef enum logic [1:0] {
        BK_FIXED = 2'd0,
        BK_INCR  = 2'd1,
        BK_WRAP  = 2'd2,
        BK_RSVD  = 2'd3
    } burst_kind_e;

    typedef struct packed {
        burst_kind_e kind;
        logic [7:0]  len;
        logic [2:0]  size;
    } burst_cfg_t;

    // Wrapping bursts accept only power-of-two beat counts 2..16.
    function automatic logic wrap_len_ok(input logic [7:0] len);
        return (len == 8'd1) || (len == 8'd3) || (len == 8'd7) || (len == 8'd15);
    endfunction

    function automatic logic req_legal(input burst_cfg_t cfg,
                                       input logic [7:0] addr_low,
                                       input int unsigned size_max);
        logic [7:0] size_ones;
        size_ones = (8'd1 << cfg.size) - 8'd1;
        if (cfg.kind == BK_RSVD) return 1'b0;
        if (int'(cfg.size) > int'(size_max)) return 1'b0;
        if (cfg.kind == BK_WRAP) begin
            if (!wrap_len_ok(cfg.len)) return 1'b0;
            if ((addr_low & size_ones) != 8'd0) return 1'b0;
        end
        return 1'b1;
    endfunction

endpackage

// File: rtl/burst_beat_ctl.sv
`timescale 1ns/1ps
module burst_beat_ctl #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             legal,
    input  logic             advance,
    input  logic [LEN_W-1:0] len,
    output logic             busy,
    output logic             last_beat,
    output logic             done,
    output logic             step
);
    logic [LEN_W-1:0] idx_q;

    assign last_beat = busy && (idx_q == len);
    assign step      = advance && busy && !last_beat && !load;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            idx_q <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load) begin
                busy  <= legal;
                idx_q <= '0;
            end else if (advance && busy) begin
                if (last_beat) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

    assert_done_after_last_R7: assert property (@(posedge clk) disable iff (rst)
        (advance && last_beat && !load) |=> (done && !busy));

    assert_idx_in_range_R7: assert property (@(posedge clk) disable iff (rst)
        busy |-> (idx_q <= len));

    assert_idle_no_done_R9: assert property (@(posedge clk) disable iff (rst)
        (!busy && !load) |=> !done);

endmodule

// File: rtl/burst_next_addr.sv
`timescale 1ns/1ps
module burst_next_addr
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  burst_kind_e       kind,
    input  logic [2:0]        size,
    input  logic [ADDR_W-1:0] wrap_mask,
    output logic [ADDR_W-1:0] next_addr
);
    logic [ADDR_W-1:0] nbytes;
    logic [ADDR_W-1:0] aligned;
    logic [ADDR_W-1:0] bumped;

    always_comb begin
        nbytes  = ADDR_W'(1) << size;
        aligned = cur_addr & ~(nbytes - ADDR_W'(1));
        bumped  = aligned + nbytes;
        unique case (kind)
            BK_FIXED: next_addr = cur_addr;
            BK_INCR:  next_addr = bumped;
            BK_WRAP:  next_addr = (cur_addr & ~wrap_mask) | (bumped & wrap_mask);
            default:  next_addr = cur_addr;
        endcase
    end
endmodule

// File: rtl/burst_lane_mask.sv
`timescale 1ns/1ps
module burst_lane_mask #(
    parameter int BUS_BYTES = 8
) (
    input  logic                         en,
    input  logic [$clog2(BUS_BYTES)-1:0] offset,
    input  logic [2:0]                   size,
    output logic [BUS_BYTES-1:0]         mask
);
    localparam int LANE_AW = $clog2(BUS_BYTES);

    logic [LANE_AW:0] nbytes;
    logic [LANE_AW:0] blk_lo;
    logic [LANE_AW:0] blk_hi;

    always_comb begin
        nbytes = (LANE_AW+1)'(1) << size;
        blk_lo = {1'b0, offset} & ~(nbytes - (LANE_AW+1)'(1));
        blk_hi = blk_lo + nbytes;
    end

    for (genvar i = 0; i < BUS_BYTES; i++) begin : g_lane
        assign mask[i] = en && ((LANE_AW+1)'(i) >= {1'b0, offset})
                            && ((LANE_AW+1)'(i) <  blk_hi);
    end
endmodule

// File: rtl/burst_addr_gen.sv
`timescale 1ns/1ps
module burst_addr_gen
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int BUS_BYTES = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic [ADDR_W-1:0]    start_addr,
    input  logic [7:0]           burst_len,
    input  logic [2:0]           beat_size,
    input  logic [1:0]           burst_kind,
    input  logic                 advance,
    output logic [ADDR_W-1:0]    beat_addr,
    output logic [BUS_BYTES-1:0] lane_mask,
    output logic                 busy,
    output logic                 last_beat,
    output logic                 done,
    output logic                 bad_req
);
    localparam int SIZE_MAX = $clog2(BUS_BYTES);
    localparam int LANE_AW  = $clog2(BUS_BYTES);

    burst_cfg_t        req_cfg;
    burst_cfg_t        cfg_q;
    logic              legal;
    logic              step;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] wmask_q;
    logic [ADDR_W-1:0] addr_nxt;

    always_comb begin
        req_cfg.kind = burst_kind_e'(burst_kind);
        req_cfg.len  = burst_len;
        req_cfg.size = beat_size;
        legal        = req_legal(req_cfg, start_addr[7:0], SIZE_MAX);
    end

    burst_beat_ctl #(.LEN_W(8)) ctl_i (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .legal     (legal),
        .advance   (advance),
        .len       (cfg_q.len),
        .busy      (busy),
        .last_beat (last_beat),
        .done      (done),
        .step      (step)
    );

    burst_next_addr #(.ADDR_W(ADDR_W)) nxt_i (
        .cur_addr  (addr_q),
        .kind      (cfg_q.kind),
        .size      (cfg_q.size),
        .wrap_mask (wmask_q),
        .next_addr (addr_nxt)
    );

    burst_lane_mask #(.BUS_BYTES(BUS_BYTES)) lane_i (
        .en     (busy),
        .offset (addr_q[LANE_AW-1:0]),
        .size   (cfg_q.size),
        .mask   (lane_mask)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '{kind: BK_FIXED, len: 8'd0, size: 3'd0};
            addr_q  <= '0;
            wmask_q <= '0;
            bad_req <= 1'b0;
        end else if (load) begin
            bad_req <= !legal;
            if (legal) begin
                cfg_q   <= req_cfg;
                addr_q  <= start_addr;
                wmask_q <= ((ADDR_W'(burst_len) + ADDR_W'(1)) << beat_size) - ADDR_W'(1);
            end
        end else if (step) begin
            addr_q <= addr_nxt;
        end
    end

    assign beat_addr = addr_q;

    assert_load_start_R2: assert property (@(posedge clk) disable iff (rst)
        (load && legal) |=> (busy && beat_addr == $past(start_addr)));

    assert_fixed_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (step && cfg_q.kind == BK_FIXED) |=> $stable(beat_addr));

    assert_wrap_window_R5: assert property (@(posedge clk) disable iff (rst)
        (step && cfg_q.kind == BK_WRAP) |=>
            ((beat_addr & ~wmask_q) == ($past(beat_addr) & ~wmask_q)));

    assert_mask_busy_R6: assert property (@(posedge clk) disable iff (rst)
        busy == (lane_mask != '0));

    assert_refused_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (load && !legal) |=> (bad_req && !busy));

endmodule

// File: tb/burst_addr_gen_tb_top.sv
`timescale 1ns/1ps
module burst_addr_gen_tb_top;
    localparam int AW = 32;
    localparam int BB = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          load;
    logic [AW-1:0] start_addr;
    logic [7:0]    burst_len;
    logic [2:0]    beat_size;
    logic [1:0]    burst_kind;
    logic          advance;
    logic [AW-1:0] beat_addr;
    logic [BB-1:0] lane_mask;
    logic          busy, last_beat, done, bad_req;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW), .BUS_BYTES(BB)) dut_i (
        .clk(clk), .rst(rst), .load(load), .start_addr(start_addr),
        .burst_len(burst_len), .beat_size(beat_size), .burst_kind(burst_kind),
        .advance(advance), .beat_addr(beat_addr), .lane_mask(lane_mask),
        .busy(busy), .last_beat(last_beat), .done(done), .bad_req(bad_req)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] ref_addr(input logic [AW-1:0] st, input int sz,
                                               input int len, input int kind, input int i);
        longint nb, win, base;
        nb = longint'(1) << sz;
        if (kind == 0) return st;
        if (kind == 1) begin
            if (i == 0) return st;
            return AW'((longint'(st) / nb) * nb + longint'(i) * nb);
        end
        win  = nb * (len + 1);
        base = (longint'(st) / win) * win;
        return AW'(base + ((longint'(st) - base) + longint'(i) * nb) % win);
    endfunction

    function automatic logic [BB-1:0] ref_mask(input logic [AW-1:0] a, input int sz);
        int off, lo, nb;
        logic [BB-1:0] m;
        nb  = 1 << sz;
        off = int'(a % BB);
        lo  = (off / nb) * nb;
        m   = '0;
        for (int k = 0; k < BB; k++) m[k] = (k >= off) && (k < lo + nb);
        return m;
    endfunction

    task automatic do_load(input logic [AW-1:0] st, input int len, input int sz, input int kind);
        @(negedge clk);
        load = 1'b1; start_addr = st; burst_len = 8'(len);
        beat_size = 3'(sz); burst_kind = 2'(kind);
        @(negedge clk);
        load = 1'b0;
    endtask

    task automatic pulse_adv();
        advance = 1'b1;
        @(negedge clk);
        advance = 1'b0;
    endtask

    // Runs a whole legal burst and checks every beat against the reference.
    task automatic run_burst(input string req, input logic [AW-1:0] st,
                             input int len, input int sz, input int kind);
        logic [AW-1:0] ea;
        do_load(st, len, sz, kind);
        chk("R2", "busy after load", busy, 1);
        chk("R8", "bad_req cleared by legal load", bad_req, 0);
        for (int i = 0; i <= len; i++) begin
            ea = ref_addr(st, sz, len, kind, i);
            chk(req, $sformatf("beat %0d addr", i), beat_addr, ea);
            chk("R6", $sformatf("beat %0d mask", i), lane_mask, ref_mask(ea, sz));
            chk("R7", $sformatf("beat %0d last", i), last_beat, (i == len));
            pulse_adv();
        end
        chk("R7", "done after last", done, 1);
        chk("R7", "busy after last", busy, 0);
        chk("R6", "idle mask", lane_mask, 0);
        @(negedge clk);
        chk("R7", "done one cycle", done, 0);
    endtask

    task automatic t_reset();
        chk("R1", "busy", busy, 0);
        chk("R1", "last", last_beat, 0);
        chk("R1", "done", done, 0);
        chk("R1", "bad", bad_req, 0);
        chk("R1", "mask", lane_mask, 0);
        chk("R1", "addr", beat_addr, 0);
    endtask

    task automatic t_incr();
        run_burst("R3", 32'h1000, 3, 3, 1);
        run_burst("R3", 32'h1003, 3, 3, 1);
        chk("R6", "unaligned first mask literal", ref_mask(32'h1003, 3), 8'hF8);
        run_burst("R3", 32'h1006, 2, 1, 1);
        run_burst("R3", 32'h2001, 0, 0, 1);
    endtask

    task automatic t_fixed();
        run_burst("R4", 32'h2004, 2, 2, 0);
        run_burst("R4", 32'h3005, 3, 3, 0);
    endtask

    task automatic t_wrap();
        run_burst("R5", 32'h1008, 3, 3, 2);
        chk("R5", "fold literal", ref_addr(32'h1008, 3, 3, 2, 3), 32'h1000);
        run_burst("R5", 32'h010C, 1, 2, 2);
        run_burst("R5", 32'h4036, 15, 1, 2);
    endtask

    task automatic refused(input string what, input logic [AW-1:0] st,
                           input int len, input int sz, input int kind);
        do_load(st, len, sz, kind);
        chk("R8", {what, " bad_req"}, bad_req, 1);
        chk("R8", {what, " busy"}, busy, 0);
        chk("R8", {what, " mask"}, lane_mask, 0);
    endtask

    task automatic t_illegal();
        refused("wrap len 3 beats", 32'h1000, 2, 3, 2);
        refused("wrap unaligned", 32'h1003, 3, 3, 2);
        refused("reserved kind", 32'h1000, 1, 0, 3);
        refused("oversize", 32'h1000, 1, 4, 1);
        run_burst("R3", 32'h1000, 1, 3, 1);
    endtask

    task automatic t_idle_adv();
        logic [AW-1:0] held;
        held = beat_addr;
        pulse_adv();
        chk("R9", "done on idle advance", done, 0);
        chk("R9", "busy on idle advance", busy, 0);
        chk("R9", "addr on idle advance", beat_addr, held);
        chk("R9", "mask on idle advance", lane_mask, 0);
    endtask

    task automatic t_reload();
        do_load(32'h5000, 7, 2, 1);
        pulse_adv();
        pulse_adv();
        do_load(32'h6010, 1, 3, 1);
        chk("R2", "reload addr", beat_addr, 32'h6010);
        chk("R2", "reload last", last_beat, 0);
        pulse_adv();
        chk("R2", "reload beat 1", beat_addr, 32'h6018);
        chk("R7", "reload last beat", last_beat, 1);
        pulse_adv();
        chk("R7", "reload done", done, 1);
        @(negedge clk);
    endtask

    initial begin
        rst = 1'b1; load = 1'b0; advance = 1'b0;
        start_addr = '0; burst_len = '0; beat_size = '0; burst_kind = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_incr();
        t_fixed();
        t_wrap();
        t_illegal();
        t_idle_adv();
        t_reload();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule